// File: doc/BRIEF.md
# Indirect Volume Register Port

This block sits between a small host controller and the gain stages of a stereo audio front end. It holds nineteen six-bit volume words. The host reaches them through a narrow six-bit data bus with an active-low chip select, separate active-low write and read strobes, and one select line. With the select line low, an access reaches a pointer register that names one of the volume words. With it high, the access reaches the word that the pointer names. Several accesses may run back to back while chip select stays low, and each one picks pointer or data again through the select line.

The host pins are asynchronous. The block brings them into the master clock domain through a two-flop synchronizer. A write takes effect on the trailing (rising) edge of the write strobe. A read drives the selected value while the read strobe is low. The block also drives the enable and direction signals for an external bus transceiver.

Each volume word is split into a mute flag and a five-bit attenuation code, and both are presented continuously to the analog side. Words 0 to 8 feed the input channels, 9 to 16 the input-to-output mixer paths, and 17 and 18 the converter-to-output paths. Turning the codes into analog gain is done elsewhere.

Top module: `volreg_port`

## Requirements
- R1: After reset, every volume word holds binary 100000: mute flag set, attenuation code 0. The pointer holds 0 and the data bus is not driven.
- R2: A write with reg_sel low loads the six-bit bus value into the pointer. A read with reg_sel low returns the pointer value, including values above 18.
- R3: A write with reg_sel high loads the bus value into the word whose index equals the pointer. No other word changes.
- R4: A read with reg_sel high drives the addressed word onto bus_out, with bus_oe high, while the synchronized read strobe is low.
- R5: While cs_n is high, bus_oe stays low, whatever the strobes do, and a write strobe changes no word and does not change the pointer.
- R6: buf_dir is high except while the block drives the bus, when it is low. buf_en_n is low while the chip is selected and high otherwise.
- R7: For word i, mute_o[i] is bit 5 of the word and atten_o[5*i+4 : 5*i] is bits 4..0. Code 0 means no attenuation; each step adds 1.5 dB, up to code 31.
- R8: A data write while the pointer is above 18 changes no word. A data read while the pointer is above 18 returns 0.
- R9: The pointer does not advance after a data access. Pointer and data cycles may follow each other with cs_n held low throughout.
- R10: A write takes effect only after the write strobe returns high. While the strobe is held low, the outputs keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| reg_sel | input | 1 | 0 selects the pointer, 1 selects the addressed word |
| bus_in | input | 6 | Data from the host bus |
| bus_out | output | 6 | Data to the host bus, valid while bus_oe is high |
| bus_oe | output | 1 | High while the block drives the bus |
| buf_en_n | output | 1 | Transceiver enable, low while selected |
| buf_dir | output | 1 | Transceiver direction, high for host-to-block |
| mute_o | output | 19 | Mute flag of each volume word |
| atten_o | output | 95 | Five-bit attenuation code of each word, word i at bits 5*i+4..5*i |

## Verification
A corrupt pointer shows up at the next pointer read-back. It also shows up as a write that lands in the wrong word, and that is visible on mute_o and atten_o three clocks after the strobe rises. A bad edge detector shows up in one of two ways: outputs change while the write strobe is still low, or a back-to-back sequence under one chip select drops or repeats a commit. Faults in out-of-range handling and in chip-select gating show up as a word that changes when it should not, or as a nonzero or unexpected read drive. The full set of mute and attenuation outputs is compared against a reference model after every write.

// File: rtl/volreg_pkg.sv
package volreg_pkg;

    // Width of the host data bus and of each volume word
    localparam int BUS_W  = 6;
    // Attenuation code occupies the bits below the mute flag
    localparam int CODE_W = BUS_W - 1;

    typedef logic [BUS_W-1:0] word_t;

    // Host pins as sampled into the clock domain
    typedef struct packed {
        logic  cs_n;
        logic  wr_n;
        logic  rd_n;
        logic  sel;
        word_t data;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1,
                                    sel: 1'b0, data: '0};

    // Reset content of every volume word: mute set, code zero
    localparam word_t MUTE_WORD = word_t'(1) << CODE_W;

endpackage

// File: rtl/volreg_sync.sv
module volreg_sync
    import volreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_i,
    output pins_t now_o
);

    typedef struct packed {
        pins_t [STAGES-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= sync_t'({STAGES{PINS_IDLE}});
        end else begin
            sync_q <= sync_d;
        end
    end

    assign now_o = sync_q.pipe[STAGES-1];

endmodule

// File: rtl/volreg_ctrl.sv
module volreg_ctrl
    import volreg_pkg::*;
#(
    parameter int NUM_REGS = 19
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_n_i,
    input  logic  wr_n_i,
    input  logic  sel_i,
    input  word_t data_i,
    output word_t ptr_o,
    output logic  we_o,
    output word_t waddr_o,
    output word_t wdata_o
);

    localparam word_t LAST_IDX = word_t'(NUM_REGS - 1);

    // Pointer plus the previous synchronized sample, used to find the
    // trailing edge of the write strobe and to hold the bus value that
    // was present while the strobe was low.
    typedef struct packed {
        word_t ptr;
        logic  cs_n_p;
        logic  wr_n_p;
        logic  sel_p;
        word_t data_p;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  wr_done;

    always_comb begin
        ctrl_d        = ctrl_q;
        ctrl_d.cs_n_p = cs_n_i;
        ctrl_d.wr_n_p = wr_n_i;
        ctrl_d.sel_p  = sel_i;
        ctrl_d.data_p = data_i;

        // Strobe was low with the chip selected and is now high
        wr_done = !ctrl_q.wr_n_p && wr_n_i && !ctrl_q.cs_n_p;

        if (wr_done && !ctrl_q.sel_p) begin
            ctrl_d.ptr = ctrl_q.data_p;
        end

        we_o    = wr_done && ctrl_q.sel_p && (ctrl_q.ptr <= LAST_IDX);
        waddr_o = ctrl_q.ptr;
        wdata_o = ctrl_q.data_p;
        ptr_o   = ctrl_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{ptr: '0, cs_n_p: 1'b1, wr_n_p: 1'b1,
                        sel_p: 1'b0, data_p: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/volreg_bank.sv
module volreg_bank
    import volreg_pkg::*;
#(
    parameter int NUM_REGS = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  word_t                      waddr_i,
    input  word_t                      wdata_i,
    output word_t [NUM_REGS-1:0]       regs_o,
    output logic  [NUM_REGS-1:0]       mute_o,
    output logic  [NUM_REGS*CODE_W-1:0] atten_o
);

    typedef struct packed {
        word_t [NUM_REGS-1:0] r;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (waddr_i == word_t'(i)) begin
                    bank_d.r[i] = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.r <= {NUM_REGS{MUTE_WORD}};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_o = bank_q.r;

    // Split each word into its flag and its code
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_split
        assign mute_o[g]                    = bank_q.r[g][CODE_W];
        assign atten_o[g*CODE_W +: CODE_W] = bank_q.r[g][CODE_W-1:0];
    end

endmodule

// File: rtl/volreg_rdport.sv
module volreg_rdport
    import volreg_pkg::*;
#(
    parameter int NUM_REGS = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_i,
    input  logic                 rd_n_i,
    input  logic                 sel_i,
    input  word_t                ptr_i,
    input  word_t [NUM_REGS-1:0] regs_i,
    output word_t                bus_out_o,
    output logic                 bus_oe_o,
    output logic                 buf_en_n_o,
    output logic                 buf_dir_o
);

    typedef struct packed {
        word_t dout;
        logic  oe;
        logic  en_n;
        logic  dir;
    } rd_t;

    rd_t   rd_d, rd_q;
    logic  rd_active;
    word_t word_val;
    word_t pick;

    always_comb begin
        rd_d = rd_q;

        // Out-of-range pointers read as zero
        word_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr_i == word_t'(i)) begin
                word_val = regs_i[i];
            end
        end

        pick      = sel_i ? word_val : ptr_i;
        rd_active = !cs_n_i && !rd_n_i;

        rd_d.dout = rd_active ? pick : '0;
        rd_d.oe   = rd_active;
        rd_d.en_n = cs_n_i;
        rd_d.dir  = !rd_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{dout: '0, oe: 1'b0, en_n: 1'b1, dir: 1'b1};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_out_o  = rd_q.dout;
    assign bus_oe_o   = rd_q.oe;
    assign buf_en_n_o = rd_q.en_n;
    assign buf_dir_o  = rd_q.dir;

endmodule

// File: rtl/volreg_port.sv
module volreg_port
    import volreg_pkg::*;
#(
    parameter int NUM_REGS    = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        wr_n,
    input  logic                        rd_n,
    input  logic                        reg_sel,
    input  logic [BUS_W-1:0]            bus_in,
    output logic [BUS_W-1:0]            bus_out,
    output logic                        bus_oe,
    output logic                        buf_en_n,
    output logic                        buf_dir,
    output logic [NUM_REGS-1:0]         mute_o,
    output logic [NUM_REGS*CODE_W-1:0]  atten_o
);

    pins_t                pins_w;
    pins_t                now_w;
    word_t                ptr_w;
    logic                 we_w;
    word_t                waddr_w;
    word_t                wdata_w;
    word_t [NUM_REGS-1:0] regs_w;

    assign pins_w.cs_n = cs_n;
    assign pins_w.wr_n = wr_n;
    assign pins_w.rd_n = rd_n;
    assign pins_w.sel  = reg_sel;
    assign pins_w.data = bus_in;

    volreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_w),
        .now_o  (now_w)
    );

    volreg_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (now_w.cs_n),
        .wr_n_i  (now_w.wr_n),
        .sel_i   (now_w.sel),
        .data_i  (now_w.data),
        .ptr_o   (ptr_w),
        .we_o    (we_w),
        .waddr_o (waddr_w),
        .wdata_o (wdata_w)
    );

    volreg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (wdata_w),
        .regs_o  (regs_w),
        .mute_o  (mute_o),
        .atten_o (atten_o)
    );

    volreg_rdport #(.NUM_REGS(NUM_REGS)) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (now_w.cs_n),
        .rd_n_i     (now_w.rd_n),
        .sel_i      (now_w.sel),
        .ptr_i      (ptr_w),
        .regs_i     (regs_w),
        .bus_out_o  (bus_out),
        .bus_oe_o   (bus_oe),
        .buf_en_n_o (buf_en_n),
        .buf_dir_o  (buf_dir)
    );

endmodule

// File: rtl/volreg_chk.sv
module volreg_chk
    import volreg_pkg::*;
#(
    parameter int NUM_REGS    = 19,
    parameter int SYNC_STAGES = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_n,
    input logic                       wr_n,
    input logic                       rd_n,
    input logic                       reg_sel,
    input logic                       bus_oe,
    input logic                       buf_en_n,
    input logic                       buf_dir,
    input logic [NUM_REGS-1:0]        mute_o,
    input logic [NUM_REGS*CODE_W-1:0] atten_o
);

    // Pin-to-drive lag: sync stages plus the output register
    localparam int OE_LAG = SYNC_STAGES + 1;
    // Pin-to-word lag for the strobe-high sample; the low sample is one earlier
    localparam int WR_LAG = SYNC_STAGES + 1;

    // R5: the bus is driven only for a selected access
    p_drive_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(cs_n, OE_LAG));

    // R4: the bus is driven only for a read strobe
    p_drive_needs_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(rd_n, OE_LAG));

    // R6: transceiver enabled and turned outward while driving
    p_buffer_with_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!buf_en_n && !buf_dir));

    // R10: a word changes only after a selected data write strobe has risen
    p_change_after_trailing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mute_o, atten_o}) |->
            ($past(wr_n, WR_LAG) && !$past(wr_n, WR_LAG + 1) &&
             !$past(cs_n, WR_LAG + 1) && $past(reg_sel, WR_LAG + 1)));

endmodule

bind volreg_port volreg_chk #(
    .NUM_REGS    (NUM_REGS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .reg_sel  (reg_sel),
    .bus_oe   (bus_oe),
    .buf_en_n (buf_en_n),
    .buf_dir  (buf_dir),
    .mute_o   (mute_o),
    .atten_o  (atten_o)
);

// File: tb/tb_volreg_port.sv
module tb_volreg_port;
    import volreg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic wr_n = 1'b1;
    logic rd_n = 1'b1;
    logic reg_sel = 1'b0;
    logic [5:0] bus_in = '0;
    logic [5:0] bus_out;
    logic bus_oe, buf_en_n, buf_dir;
    logic [NREG-1:0]   mute_o;
    logic [NREG*5-1:0] atten_o;

    volreg_port #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .reg_sel(reg_sel), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .buf_en_n(buf_en_n), .buf_dir(buf_dir),
        .mute_o(mute_o), .atten_o(atten_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic [5:0] model[NREG];
    logic [5:0] ptr_m;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < NREG; i++) begin
            if (bad < 0 && ({mute_o[i], atten_o[i*5 +: 5]} != model[i])) bad = i;
        end
        if (bad < 0) check(1'b1, tag, "word outputs", 0, 0);
        else check(1'b0, tag, $sformatf("word %0d outputs", bad),
                   {mute_o[bad], atten_o[bad*5 +: 5]}, model[bad]);
    endtask

    task automatic wr_cycle(input bit sel, input logic [5:0] d, input bit keep,
                            input bit selected = 1'b1);
        @(negedge clk);
        cs_n = !selected; reg_sel = sel; bus_in = d;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        if (!keep) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (selected) begin
            if (!sel) ptr_m = d;
            else if (ptr_m < NREG) model[ptr_m] = d;
        end
    endtask

    task automatic rd_cycle(input bit sel, input string tag, input bit keep);
        logic [5:0] e;
        if (sel) e = (ptr_m < NREG) ? model[ptr_m] : 6'd0;
        else     e = ptr_m;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cs_n = 1'b0; reg_sel = sel;
        repeat (3) @(negedge clk);
        rd_n = 1'b0;
        repeat (8) @(negedge clk);
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        if (!keep) cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops one expected value at the start of each drive window
    initial begin
        logic was = 1'b0;
        logic [5:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (bus_oe && !was) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected bus drive", bus_out, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_out == e, t, "read data", bus_out, e);
                    check(!buf_en_n && !buf_dir, "R6", "buffer controls in read",
                          {buf_en_n, buf_dir}, 0);
                end
            end
            was = bus_oe;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 6'b100000;
        ptr_m = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check_regs("R1");
        check(bus_oe == 1'b0, "R1", "bus_oe after reset", bus_oe, 0);
        check(buf_dir && buf_en_n, "R6", "idle buffer controls", {buf_en_n, buf_dir}, 3);
        rd_cycle(1'b0, "R2", 1'b0);
        rd_cycle(1'b1, "R1", 1'b0);

        // R3, R7: single data write
        wr_cycle(1'b0, 6'd5, 1'b0);
        wr_cycle(1'b1, 6'h0A, 1'b0);
        check_regs("R3");
        check(!mute_o[5] && atten_o[25 +: 5] == 5'd10, "R7", "word 5 split",
              {mute_o[5], atten_o[25 +: 5]}, 6'h0A);
        rd_cycle(1'b1, "R4", 1'b0);
        rd_cycle(1'b0, "R9", 1'b0);

        wr_cycle(1'b1, 6'h3F, 1'b0);
        check(mute_o[5] && atten_o[25 +: 5] == 5'd31, "R7", "word 5 muted max",
              {mute_o[5], atten_o[25 +: 5]}, 6'h3F);
        check_regs("R7");

        // R9: back-to-back cycles under one chip select
        wr_cycle(1'b0, 6'd17, 1'b1);
        wr_cycle(1'b1, 6'h13, 1'b1);
        wr_cycle(1'b0, 6'd18, 1'b1);
        wr_cycle(1'b1, 6'h01, 1'b1);
        rd_cycle(1'b1, "R9", 1'b1);
        wr_cycle(1'b0, 6'd0, 1'b1);
        wr_cycle(1'b1, 6'h00, 1'b0);
        check_regs("R9");
        check(!mute_o[0] && atten_o[4:0] == 5'd0, "R7", "word 0 unmuted",
              {mute_o[0], atten_o[4:0]}, 0);

        // R8: out-of-range pointer
        wr_cycle(1'b0, 6'd19, 1'b0);
        wr_cycle(1'b1, 6'h07, 1'b0);
        check_regs("R8");
        rd_cycle(1'b1, "R8", 1'b0);
        rd_cycle(1'b0, "R2", 1'b0);
        wr_cycle(1'b0, 6'd63, 1'b0);
        wr_cycle(1'b1, 6'h00, 1'b0);
        check_regs("R8");
        rd_cycle(1'b1, "R8", 1'b0);

        // R5: deselected strobes
        wr_cycle(1'b0, 6'd2, 1'b0);
        @(negedge clk);
        cs_n = 1'b1; reg_sel = 1'b1; rd_n = 1'b0;
        repeat (8) @(negedge clk);
        check(bus_oe == 1'b0, "R5", "bus_oe while deselected", bus_oe, 0);
        check(buf_en_n && buf_dir, "R6", "buffer controls while deselected",
              {buf_en_n, buf_dir}, 3);
        rd_n = 1'b1;
        wr_cycle(1'b1, 6'h11, 1'b0, 1'b0);
        check_regs("R5");
        rd_cycle(1'b0, "R5", 1'b0);
        rd_cycle(1'b1, "R5", 1'b0);

        // R10: commit waits for the trailing edge
        @(negedge clk);
        cs_n = 1'b0; reg_sel = 1'b1; bus_in = 6'h09;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check(mute_o[2] && atten_o[10 +: 5] == 5'd0, "R10", "word 2 during strobe",
              {mute_o[2], atten_o[10 +: 5]}, 6'h20);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!mute_o[2] && atten_o[10 +: 5] == 5'd9, "R10", "word 2 after strobe",
              {mute_o[2], atten_o[10 +: 5]}, 6'h09);
        cs_n = 1'b1;
        model[2] = 6'h09;
        check_regs("R10");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4", "reads never driven", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule